// File: doc/BRIEF.md
# Four-Word Ascending Sorter

This block takes four unsigned words and returns the same four words in ascending order, with the smallest on output lane 0 and the largest on lane 3. It is purely combinational. It has no clock, no reset and no state, so a change on any input reaches the outputs within the same cycle.

The sorter is a fixed network of five compare-and-swap elements arranged in three levels. Each element computes one greater-than bit. That bit drives the selects of two word-wide multiplexers: one passes the larger word and the other passes the smaller. The smaller word always goes to the lower-numbered lane.

The first level orders the pairs of lanes (0,1) and (2,3). The second level orders the pairs (0,2) and (1,3). The third level orders the pair (1,2). Which lanes are compared never depends on the data, so the longest path is three compare-and-swap delays.

Top module: `sort4`

## Requirements
- R1: The outputs are in ascending unsigned order: out0 <= out1 <= out2 <= out3 for every input combination.
- R2: The outputs are a permutation of the inputs: every input value appears on the outputs exactly as many times as it appears on the inputs.
- R3: Words are compared as unsigned numbers, so a word with its top bit set (for example 8'hFF or 8'h80) sorts above any word with a clear top bit (for example 8'h01 or 8'h7F).
- R4: out0 carries the minimum of the four inputs and out3 carries the maximum. Both are already settled after the second level, and the third level does not alter them.
- R5: Repeated values are kept. Four equal inputs give four equal outputs, and two pairs of equal values come out as two adjacent equal pairs.
- R6: The outputs depend only on the multiset of input values. All 24 orderings of the same four words on in0..in3 give identical outputs.
- R7: The block has no storage. The outputs reflect the present inputs with zero clock cycles of latency.
- R8: The word width is a parameter W with a default of 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in0 | input | W | Unsorted word on lane 0 |
| in1 | input | W | Unsorted word on lane 1 |
| in2 | input | W | Unsorted word on lane 2 |
| in3 | input | W | Unsorted word on lane 3 |
| out0 | output | W | Smallest word |
| out1 | output | W | Second smallest word |
| out2 | output | W | Second largest word |
| out3 | output | W | Largest word |

## Verification
Every result is due in the same cycle as its stimulus, zero clock edges later, because the path from input to output contains no register. The bench changes inputs on the falling edge of its clock and reads the outputs one time unit later. It never waits for a rising edge, so any latency added to the block would show up as a mismatch. The expected values come from a hand-written table and from an insertion sort inside the bench.

// File: rtl/sort4.sv
module sort4 #(
  parameter int W = 8
) (
  input  logic [W-1:0] in0,
  input  logic [W-1:0] in1,
  input  logic [W-1:0] in2,
  input  logic [W-1:0] in3,
  output logic [W-1:0] out0,
  output logic [W-1:0] out1,
  output logic [W-1:0] out2,
  output logic [W-1:0] out3
);

  // level 1: lanes (0,1) and (2,3)
  logic gt_a, gt_b;
  logic [W-1:0] s1_0, s1_1, s1_2, s1_3;
  assign gt_a = in0 > in1;
  assign s1_0 = gt_a ? in1 : in0;
  assign s1_1 = gt_a ? in0 : in1;
  assign gt_b = in2 > in3;
  assign s1_2 = gt_b ? in3 : in2;
  assign s1_3 = gt_b ? in2 : in3;

  // level 2: lanes (0,2) and (1,3)
  logic gt_c, gt_d;
  logic [W-1:0] s2_0, s2_1, s2_2, s2_3;
  assign gt_c = s1_0 > s1_2;
  assign s2_0 = gt_c ? s1_2 : s1_0;
  assign s2_2 = gt_c ? s1_0 : s1_2;
  assign gt_d = s1_1 > s1_3;
  assign s2_1 = gt_d ? s1_3 : s1_1;
  assign s2_3 = gt_d ? s1_1 : s1_3;

  // level 3: middle lanes
  logic gt_e;
  assign gt_e = s2_1 > s2_2;
  assign out0 = s2_0;
  assign out1 = gt_e ? s2_2 : s2_1;
  assign out2 = gt_e ? s2_1 : s2_2;
  assign out3 = s2_3;

endmodule

// File: rtl/sort4_chk.sv
module sort4_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] in0,
  input logic [W-1:0] in1,
  input logic [W-1:0] in2,
  input logic [W-1:0] in3,
  input logic [W-1:0] out0,
  input logic [W-1:0] out1,
  input logic [W-1:0] out2,
  input logic [W-1:0] out3,
  input logic [W-1:0] mid_lo,
  input logic [W-1:0] mid_hi
);

  logic [W+1:0] sum_in, sum_out;
  logic [W-1:0] x_in, x_out, lo, hi;

  always_comb begin
    sum_in  = {2'b00, in0} + {2'b00, in1} + {2'b00, in2} + {2'b00, in3};
    sum_out = {2'b00, out0} + {2'b00, out1} + {2'b00, out2} + {2'b00, out3};
    x_in    = in0 ^ in1 ^ in2 ^ in3;
    x_out   = out0 ^ out1 ^ out2 ^ out3;
    lo = in0;
    if (in1 < lo) lo = in1;
    if (in2 < lo) lo = in2;
    if (in3 < lo) lo = in3;
    hi = in0;
    if (in1 > hi) hi = in1;
    if (in2 > hi) hi = in2;
    if (in3 > hi) hi = in3;
  end

  always_comb begin
    a_r1_ascending: assert (out0 <= out1 && out1 <= out2 && out2 <= out3);
    a_r2_sum_kept: assert (sum_in == sum_out);
    a_r2_parity_kept: assert (x_in == x_out);
    a_r3_top_bit_wins: assert (!(in0[W-1] | in1[W-1] | in2[W-1] | in3[W-1]) || out3[W-1]);
    a_r4_extremes: assert (out0 == lo && out3 == hi);
    a_r4_level2_ends: assert (mid_lo == out0 && mid_hi == out3);
  end

endmodule

bind sort4 sort4_chk #(.W(W)) u_chk (
  .in0(in0), .in1(in1), .in2(in2), .in3(in3),
  .out0(out0), .out1(out1), .out2(out2), .out3(out3),
  .mid_lo(s2_0), .mid_hi(s2_3)
);

// File: tb/sort4_bench.sv
module sort4_bench;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {in0,in1,in2,in3, exp0,exp1,exp2,exp3}
  localparam logic [63:0] VEC [NVEC] = '{
    64'h04030201_01020304,
    64'h01020304_01020304,
    64'hFF01807F_017F80FF,
    64'h05050505_05050505,
    64'h10001000_00001010,
    64'h00FF00FF_0000FFFF,
    64'h3CA53C12_123C3CA5,
    64'h09C86432_093264C8
  };

  logic clk = 1'b0;
  logic [W-1:0] in0, in1, in2, in3;
  logic [W-1:0] out0, out1, out2, out3;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sort4 #(.W(W)) u_sort4 (
    .in0(in0), .in1(in1), .in2(in2), .in3(in3),
    .out0(out0), .out1(out1), .out2(out2), .out3(out3)
  );

  task automatic check(input string req, input logic [4*W-1:0] got, input logic [4*W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] c, input logic [W-1:0] d);
    @(negedge clk);
    in0 = a; in1 = b; in2 = c; in3 = d;
    #1;
  endtask

  function automatic logic [4*W-1:0] ref_sort(input logic [W-1:0] a, input logic [W-1:0] b,
                                               input logic [W-1:0] c, input logic [W-1:0] d);
    logic [W-1:0] v [4];
    logic [W-1:0] t;
    v[0] = a; v[1] = b; v[2] = c; v[3] = d;
    for (int i = 1; i < 4; i++)
      for (int j = i; j > 0; j--)
        if (v[j-1] > v[j]) begin t = v[j]; v[j] = v[j-1]; v[j-1] = t; end
    return {v[0], v[1], v[2], v[3]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog got=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] p [4];
    logic [4*W-1:0] first;
    // R7: initial all-zero inputs, outputs settle with no clock edge
    drive(8'h00, 8'h00, 8'h00, 8'h00);
    check("R7 zero inputs", {out0, out1, out2, out3}, 32'h0);

    // table: R1 R3 R5 R8
    for (int k = 0; k < NVEC; k++) begin
      drive(VEC[k][63:56], VEC[k][55:48], VEC[k][47:40], VEC[k][39:32]);
      check("R1 table", {out0, out1, out2, out3}, VEC[k][31:0]);
    end

    // R3 unsigned: top-bit words above small ones
    drive(8'h80, 8'h7F, 8'h01, 8'hFE);
    check("R3 unsigned", {out0, out1, out2, out3}, 32'h017F80FE);

    // R5 duplicates in two pairs
    drive(8'hAA, 8'h11, 8'hAA, 8'h11);
    check("R5 dup pairs", {out0, out1, out2, out3}, 32'h1111AAAA);

    // R4 min and max
    drive(8'h40, 8'h00, 8'hFF, 8'h41);
    check("R4 extremes", {out0, out3}, {8'h00, 8'hFF, 16'h0} >> 16);

    // R7 change without a clock edge
    in0 = 8'h09; in1 = 8'h08; in2 = 8'h07; in3 = 8'h06;
    #1;
    check("R7 same cycle", {out0, out1, out2, out3}, 32'h06070809);

    // R6 all 24 orderings of the same four words
    p[0] = 8'h3C; p[1] = 8'hA5; p[2] = 8'h3C; p[3] = 8'h12;
    first = 32'h123C3CA5;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++)
            if (a != b && a != c && a != d && b != c && b != d && c != d) begin
              drive(p[a], p[b], p[c], p[d]);
              check("R6 ordering", {out0, out1, out2, out3}, first);
            end

    // R2 R1 R5: random words, narrow values force repeats
    for (int n = 0; n < 2000; n++) begin
      logic [W-1:0] a, b, c, d;
      a = W'($urandom); b = W'($urandom); c = W'($urandom); d = W'($urandom);
      if (n % 2 == 0) begin a &= 8'h83; b &= 8'h83; c &= 8'h83; d &= 8'h83; end
      drive(a, b, c, d);
      check("R2 reference", {out0, out1, out2, out3}, ref_sort(a, b, c, d));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule